// File: doc/BRIEF.md
# Configuration Block Fetch Sequencer

This block copies a small configuration structure from host memory into local registers by acting as a bus master. After a start strobe it takes its settings: the structure layout, the read mode and a base address. It then runs a series of bus tenures. In each tenure it requests the bus, waits for a grant, reads exactly two DWords at ascending, contiguous addresses, and then releases the request for one cycle. It repeats this until the whole structure has been read. Each DWord that belongs to the structure appears on a write port with its word index. A single-cycle done pulse marks the end of the sequence.

Two layouts are supported. In the wide layout the structure holds seven DWords, so four tenures are run. The eighth read lands on a location the structure does not use, and its data is dropped. In the narrow layout the structure holds six DWords and three tenures are run. Two read modes are supported. In non-burst mode every data phase has its own address phase, and the frame signal drops for one cycle between the two transfers of a tenure. In burst mode a tenure has one address phase, followed by two back-to-back data phases under a frame that stays high. A ready input from the slave stretches any data phase.

The controller is a six-state machine:
- **IDLE**: waits for start. On start it goes to REQ (transition *accept*).
- **REQ**: holds the request. On grant it goes to ADDR (*granted*).
- **ADDR**: drives one address phase, then goes to DATA (*issue*).
- **DATA**: waits for ready. On ready it goes to one of three states:
  - REL, if this was the last beat of the tenure (*tenure_end*);
  - DATA again, in burst mode (*burst_next*);
  - GAP, in non-burst mode (*split*).
- **GAP**: drops frame for one cycle, then goes to ADDR (*readdress*).
- **REL**: drops the request. It then goes to REQ (*next_tenure*), or, after the last tenure, to IDLE with done asserted (*finish*).

Top module: `cfgfetch_seq`

## Requirements
- R1: After reset the block is idle. `busy`, `bus_req`, `bus_frame`, `bus_addr_valid`, `cfg_we` and `done` are all 0.
- R2: `start` is accepted only while `busy` is 0. A `start` pulse while busy changes neither the layout, the mode nor the base address in use.
- R3: A tenure's first address phase comes only after a cycle with `bus_gnt` high in the request state. `bus_frame` is never high without `bus_req`. `bus_req` drops for exactly one cycle after each tenure, so a run has one such cycle per tenure.
- R4: Every tenure completes exactly two data phases (`bus_frame`=1, `bus_addr_valid`=0, `bus_rdy`=1) before the request is released.
- R5: With `wide_layout`=1 the block runs four tenures and eight data phases. The first seven DWords are written with `cfg_idx` 0..6 in order. The eighth DWord produces no write.
- R6: With `wide_layout`=0 the block runs three tenures. All six DWords are written with `cfg_idx` 0..5 in order.
- R7: The base is `base_addr` with bits [1:0] forced to 0. Word k of the sequence is read from base+4k, so `bus_addr[1:0]` is always 0 during an address phase.
- R8: With `burst_mode`=0 each data phase follows its own address phase. Between the two transfers of a tenure, `bus_frame` is low for one cycle while `bus_req` stays high. A run has twice as many address phases as tenures.
- R9: With `burst_mode`=1 each tenure has one address phase at base+8t, followed by two data phases with `bus_frame` held high and no address phase between them.
- R10: A data phase with `bus_rdy`=0 produces no write and does not advance. The word stored when `bus_rdy` rises is the one for that phase.
- R11: `done` is high for exactly one cycle, after the last kept word has been written. `busy` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe, honoured only while idle |
| wide_layout | input | 1 | 1: seven-DWord layout, 0: six-DWord layout |
| burst_mode | input | 1 | 1: burst reads, 0: one address phase per data phase |
| base_addr | input | AW | Structure base address in host memory |
| bus_req | output | 1 | Bus request, held for a whole tenure |
| bus_gnt | input | 1 | Bus grant |
| bus_frame | output | 1 | High during address and data phases |
| bus_addr_valid | output | 1 | High during an address phase |
| bus_addr | output | AW | Read address, valid with `bus_addr_valid`, 0 otherwise |
| bus_rdy | input | 1 | Slave ready, completes a data phase |
| bus_rdata | input | DW | Read data, valid with `bus_rdy` |
| cfg_we | output | 1 | Write strobe for a kept DWord |
| cfg_idx | output | IDXW | Word index of the write |
| cfg_wdata | output | DW | Data of the write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at the end of the sequence |

## Verification
The situations that are hardest to reach from the ports are two. The first is the dropped eighth read in the wide layout. The second is a start strobe that arrives in the middle of a run with different settings. The bench reaches both by sweeping both layouts, both read modes, grant delays and ready stall lengths, with base addresses whose low bits are set. In a subset of the runs it fires a second start, with every setting inverted, while the first tenure is under way. A bus-slave model in the bench answers each address with data derived arithmetically from that address. This lets every write be checked against the index and the address it must come from, and any change in the layout or base in use shows up as wrong data or wrong counts.

// File: rtl/cfgfetch_pkg.sv
package cfgfetch_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_ADDR = 3'd2,
        ST_DATA = 3'd3,
        ST_GAP  = 3'd4,
        ST_REL  = 3'd5
    } fetch_state_t;
endpackage

// File: rtl/cfgfetch_fsm.sv
module cfgfetch_fsm
    import cfgfetch_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         burst,
    input  logic         gnt,
    input  logic         rdy,
    input  logic         last_beat,
    input  logic         last_tenure,
    output fetch_state_t state,
    output logic         accept,
    output logic         beat_done,
    output logic         tenure_adv,
    output logic         finish,
    output logic         req,
    output logic         frame,
    output logic         addr_phase
);
    fetch_state_t state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = ST_REQ;         // accept
            ST_REQ:  if (gnt)   state_nx = ST_ADDR;        // granted
            ST_ADDR:            state_nx = ST_DATA;        // issue
            ST_DATA: if (rdy) begin
                if (last_beat)  state_nx = ST_REL;         // tenure_end
                else if (burst) state_nx = ST_DATA;        // burst_next
                else            state_nx = ST_GAP;         // split
            end
            ST_GAP:             state_nx = ST_ADDR;        // readdress
            ST_REL:  state_nx = last_tenure ? ST_IDLE      // finish
                                            : ST_REQ;      // next_tenure
            default:            state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept     = 1'b0;
        beat_done  = 1'b0;
        tenure_adv = 1'b0;
        finish     = 1'b0;
        req        = 1'b0;
        frame      = 1'b0;
        addr_phase = 1'b0;
        unique case (state)
            ST_IDLE: accept = start;
            ST_REQ:  req = 1'b1;
            ST_ADDR: begin
                req        = 1'b1;
                frame      = 1'b1;
                addr_phase = 1'b1;
            end
            ST_DATA: begin
                req       = 1'b1;
                frame     = 1'b1;
                beat_done = rdy;
            end
            ST_GAP:  req = 1'b1;
            ST_REL: begin
                tenure_adv = 1'b1;
                finish     = last_tenure;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cfgfetch_cursor.sv
module cfgfetch_cursor #(
    parameter  int BEATS = 2,
    parameter  int TW    = 3,
    localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          beat_done,
    input  logic          tenure_adv,
    input  logic [TW-1:0] n_ten,
    output logic [BW-1:0] beat,
    output logic [TW-1:0] tenure,
    output logic          last_beat,
    output logic          last_tenure
);
    generate
        if (BEATS == 1) begin : g_single
            assign beat      = '0;
            assign last_beat = 1'b1;
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          beat <= '0;
                else if (clear)      beat <= '0;
                else if (beat_done)  beat <= last_beat ? '0 : beat + 1'b1;
            end
            assign last_beat = (beat == BW'(BEATS - 1));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          tenure <= '0;
        else if (clear)      tenure <= '0;
        else if (tenure_adv) tenure <= tenure + 1'b1;
    end

    assign last_tenure = (tenure == n_ten - 1'b1);
endmodule

// File: rtl/cfgfetch_addr.sv
module cfgfetch_addr #(
    parameter  int AW    = 32,
    parameter  int BEATS = 2,
    parameter  int TW    = 3,
    parameter  int BW    = 1,
    localparam int STEP  = 4,
    localparam int SPAN  = BEATS * STEP
) (
    input  logic [AW-1:0] base,
    input  logic [TW-1:0] tenure,
    input  logic [BW-1:0] beat,
    output logic [AW-1:0] addr
);
    always_comb begin
        addr = base + (AW'(tenure) * AW'(SPAN)) + (AW'(beat) * AW'(STEP));
    end
endmodule

// File: rtl/cfgfetch_sink.sv
module cfgfetch_sink #(
    parameter int BEATS = 2,
    parameter int TW    = 3,
    parameter int BW    = 1,
    parameter int IDXW  = 3,
    parameter int WCW   = 3
) (
    input  logic            beat_done,
    input  logic [TW-1:0]   tenure,
    input  logic [BW-1:0]   beat,
    input  logic [WCW-1:0]  n_words,
    output logic            we,
    output logic [IDXW-1:0] idx
);
    int word_no;

    always_comb begin
        word_no = int'(tenure) * BEATS + int'(beat);
        idx     = IDXW'(word_no);
        we      = beat_done && (word_no < int'(n_words));
    end
endmodule

// File: rtl/cfgfetch_seq.sv
module cfgfetch_seq
    import cfgfetch_pkg::*;
#(
    parameter  int AW           = 32,
    parameter  int DW           = 32,
    parameter  int BEATS        = 2,
    parameter  int WORDS_WIDE   = 7,
    parameter  int WORDS_NARROW = 6,
    localparam int TEN_WIDE     = (WORDS_WIDE + BEATS - 1) / BEATS,
    localparam int TEN_NARROW   = (WORDS_NARROW + BEATS - 1) / BEATS,
    localparam int TW           = $clog2(TEN_WIDE + 1),
    localparam int BW           = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int IDXW         = $clog2(TEN_WIDE * BEATS),
    localparam int WCW          = $clog2(WORDS_WIDE + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            wide_layout,
    input  logic            burst_mode,
    input  logic [AW-1:0]   base_addr,
    output logic            bus_req,
    input  logic            bus_gnt,
    output logic            bus_frame,
    output logic            bus_addr_valid,
    output logic [AW-1:0]   bus_addr,
    input  logic            bus_rdy,
    input  logic [DW-1:0]   bus_rdata,
    output logic            cfg_we,
    output logic [IDXW-1:0] cfg_idx,
    output logic [DW-1:0]   cfg_wdata,
    output logic            busy,
    output logic            done
);
    fetch_state_t    state;
    logic            accept, beat_done, tenure_adv, finish;
    logic            last_beat, last_tenure;
    logic            wide_q, burst_q;
    logic [AW-1:0]   base_q, rd_addr;
    logic [BW-1:0]   beat;
    logic [TW-1:0]   tenure, n_ten;
    logic [WCW-1:0]  n_words;

    // settings captured on an accepted start only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide_q  <= 1'b0;
            burst_q <= 1'b0;
            base_q  <= '0;
        end else if (accept) begin
            wide_q  <= wide_layout;
            burst_q <= burst_mode;
            base_q  <= {base_addr[AW-1:2], 2'b00};
        end
    end

    assign n_ten   = wide_q ? TW'(TEN_WIDE)    : TW'(TEN_NARROW);
    assign n_words = wide_q ? WCW'(WORDS_WIDE) : WCW'(WORDS_NARROW);

    cfgfetch_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .burst       (burst_q),
        .gnt         (bus_gnt),
        .rdy         (bus_rdy),
        .last_beat   (last_beat),
        .last_tenure (last_tenure),
        .state       (state),
        .accept      (accept),
        .beat_done   (beat_done),
        .tenure_adv  (tenure_adv),
        .finish      (finish),
        .req         (bus_req),
        .frame       (bus_frame),
        .addr_phase  (bus_addr_valid)
    );

    cfgfetch_cursor #(.BEATS(BEATS), .TW(TW)) u_cursor (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (accept),
        .beat_done   (beat_done),
        .tenure_adv  (tenure_adv),
        .n_ten       (n_ten),
        .beat        (beat),
        .tenure      (tenure),
        .last_beat   (last_beat),
        .last_tenure (last_tenure)
    );

    cfgfetch_addr #(.AW(AW), .BEATS(BEATS), .TW(TW), .BW(BW)) u_addr (
        .base   (base_q),
        .tenure (tenure),
        .beat   (beat),
        .addr   (rd_addr)
    );

    cfgfetch_sink #(.BEATS(BEATS), .TW(TW), .BW(BW), .IDXW(IDXW), .WCW(WCW)) u_sink (
        .beat_done (beat_done),
        .tenure    (tenure),
        .beat      (beat),
        .n_words   (n_words),
        .we        (cfg_we),
        .idx       (cfg_idx)
    );

    assign bus_addr  = bus_addr_valid ? rd_addr : '0;
    assign cfg_wdata = bus_rdata;
    assign busy      = (state != ST_IDLE);
    assign done      = finish;
endmodule

// File: rtl/cfgfetch_checker.sv
module cfgfetch_checker
    import cfgfetch_pkg::*;
#(
    parameter int AW   = 32,
    parameter int IDXW = 3,
    parameter int WCW  = 3
) (
    input logic            clk,
    input logic            rst_n,
    input fetch_state_t    state,
    input logic            wide_q,
    input logic            burst_q,
    input logic [AW-1:0]   base_q,
    input logic            last_beat,
    input logic [WCW-1:0]  n_words,
    input logic            bus_req,
    input logic            bus_frame,
    input logic            bus_addr_valid,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_rdy,
    input logic            cfg_we,
    input logic [IDXW-1:0] cfg_idx,
    input logic            busy,
    input logic            done
);
    // R1: outside a run the bus side and write port stay quiet
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_req && !bus_frame && !cfg_we));

    // R2: captured settings do not move while a run is in progress
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(wide_q) && $stable(burst_q) && $stable(base_q)));

    // R3: frame only inside a requested tenure
    p_frame_in_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_frame |-> bus_req);

    // R5: no write past the end of the structure
    p_keep_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> (int'(cfg_idx) < int'(n_words)));

    // R7: address phases are DWord aligned
    p_addr_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr_valid |-> (bus_addr[1:0] == 2'b00));

    // R8: an address phase is followed by a data phase
    p_addr_then_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr_valid |=> (bus_frame && !bus_addr_valid));

    // R8: non-burst drops frame between the two transfers
    p_split_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && bus_rdy && !last_beat && !burst_q) |=> (!bus_frame && bus_req));

    // R9: burst keeps frame and skips the address phase
    p_burst_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && bus_rdy && !last_beat && burst_q) |=> (bus_frame && !bus_addr_valid));

    // R10: a stalled data phase writes nothing
    p_stall_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !bus_rdy) |-> !cfg_we);

    // R11: done is a single pulse and ends the run
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));
endmodule

bind cfgfetch_seq cfgfetch_checker #(.AW(AW), .IDXW(IDXW), .WCW(WCW)) i_cfgfetch_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .state          (state),
    .wide_q         (wide_q),
    .burst_q        (burst_q),
    .base_q         (base_q),
    .last_beat      (last_beat),
    .n_words        (n_words),
    .bus_req        (bus_req),
    .bus_frame      (bus_frame),
    .bus_addr_valid (bus_addr_valid),
    .bus_addr       (bus_addr),
    .bus_rdy        (bus_rdy),
    .cfg_we         (cfg_we),
    .cfg_idx        (cfg_idx),
    .busy           (busy),
    .done           (done)
);

// File: tb/test_cfgfetch_seq.sv
module test_cfgfetch_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 32;
    localparam int DW   = 32;
    localparam int IDXW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            wide_layout = 1'b0;
    logic            burst_mode = 1'b0;
    logic [AW-1:0]   base_addr = '0;
    logic            bus_req;
    logic            bus_gnt = 1'b0;
    logic            bus_frame;
    logic            bus_addr_valid;
    logic [AW-1:0]   bus_addr;
    logic            bus_rdy = 1'b0;
    logic [DW-1:0]   bus_rdata = '0;
    logic            cfg_we;
    logic [IDXW-1:0] cfg_idx;
    logic [DW-1:0]   cfg_wdata;
    logic            busy;
    logic            done;

    cfgfetch_seq i_cfgfetch_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .wide_layout(wide_layout),
        .burst_mode(burst_mode), .base_addr(base_addr), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_frame(bus_frame), .bus_addr_valid(bus_addr_valid),
        .bus_addr(bus_addr), .bus_rdy(bus_rdy), .bus_rdata(bus_rdata),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .busy(busy), .done(done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int tests = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        return (a * 32'h0001_9E37) ^ 32'h5A5A_0F0F;
    endfunction

    // run context, set by the sequencing task
    logic [AW-1:0] exp_base;
    bit            exp_wide, exp_burst;
    int            gnt_delay, stall_len;
    int            n_addr, n_data, n_wr, n_rel, n_gap;
    int            req_wait, waited;
    logic [AW-1:0] cur;
    bit            rdy_prev, gnt_prev, in_ten, got_done;

    // bus slave, arbiter and monitor
    always @(negedge clk) begin
        int exp_ten, exp_words;
        logic [AW-1:0] exp_a;
        exp_ten   = exp_wide ? 4 : 3;
        exp_words = exp_wide ? 7 : 6;
        if (rst_n) begin
            if (rdy_prev) cur = cur + 4;
            if (busy && !bus_req) n_rel++;
            if (bus_addr_valid) begin
                if (!in_ten) chk(gnt_prev, "R3 grant before first address", gnt_prev, 1);
                exp_a = exp_burst ? exp_base + 32'(8 * n_addr) : exp_base + 32'(4 * n_addr);
                chk(bus_addr == exp_a, exp_burst ? "R9 burst address" : "R7 address", bus_addr, exp_a);
                cur = bus_addr;
                n_addr++;
            end
            if (!bus_req) in_ten = 1'b0;
            else if (bus_addr_valid) in_ten = 1'b1;
            else if (!bus_frame && in_ten) n_gap++;
            if (done) begin
                chk(n_rel == exp_ten, "R3 release cycles", n_rel, exp_ten);
                chk(n_data == 2 * exp_ten, "R4 data phases", n_data, 2 * exp_ten);
                chk(n_wr == exp_words, exp_wide ? "R5 writes" : "R6 writes", n_wr, exp_words);
                chk(n_addr == (exp_burst ? exp_ten : 2 * exp_ten),
                    exp_burst ? "R9 address phases" : "R8 address phases",
                    n_addr, exp_burst ? exp_ten : 2 * exp_ten);
                chk(n_gap == (exp_burst ? 0 : exp_ten), "R8 frame gaps", n_gap, exp_burst ? 0 : exp_ten);
                got_done = 1'b1;
            end
            // arbiter
            if (bus_req && !in_ten) begin
                bus_gnt = (req_wait >= gnt_delay);
                req_wait++;
            end else begin
                bus_gnt  = 1'b0;
                req_wait = 0;
            end
            gnt_prev = bus_gnt;
            // slave
            if (bus_frame && !bus_addr_valid) begin
                if (waited >= stall_len) begin
                    bus_rdy = 1'b1;
                    waited  = 0;
                end else begin
                    bus_rdy = 1'b0;
                    waited++;
                end
                bus_rdata = mem_word(cur);
            end else begin
                bus_rdy   = 1'b0;
                bus_rdata = '0;
            end
            rdy_prev = bus_rdy;
            #1;
            if (bus_frame && !bus_addr_valid) begin
                if (!bus_rdy) begin
                    chk(!cfg_we, "R10 no write while stalled", cfg_we, 0);
                end else begin
                    chk(cfg_we == (n_data < exp_words), exp_wide ? "R5 keep or drop" : "R6 keep",
                        cfg_we, n_data < exp_words);
                    n_data++;
                end
            end
            if (cfg_we) begin
                chk(cfg_idx == IDXW'(n_wr), "R5 R6 word index", cfg_idx, n_wr);
                exp_a = exp_base + 32'(4 * n_wr);
                chk(cfg_wdata == mem_word(exp_a), "R10 R7 word data", cfg_wdata, mem_word(exp_a));
                n_wr++;
            end
        end
    end

    task automatic run_case(input bit w, input bit b, input int gd, input int st,
                            input logic [AW-1:0] base, input bit poke);
        bit finished;
        exp_base  = {base[AW-1:2], 2'b00};
        exp_wide  = w;
        exp_burst = b;
        gnt_delay = gd;
        stall_len = st;
        n_addr = 0; n_data = 0; n_wr = 0; n_rel = 0; n_gap = 0;
        req_wait = 0; waited = 0; in_ten = 1'b0; got_done = 1'b0;
        @(negedge clk); #2;
        wide_layout = w; burst_mode = b; base_addr = base; start = 1'b1;
        @(negedge clk); #2;
        start = 1'b0; wide_layout = ~w; burst_mode = ~b; base_addr = ~base;
        if (poke) begin
            // R2: second start while busy with all settings inverted
            repeat (3) @(negedge clk);
            #2 start = 1'b1;
            @(negedge clk); #2 start = 1'b0;
        end
        finished = 1'b0;
        for (int i = 0; i < 3000 && !finished; i++) begin
            @(negedge clk);
            #3;
            finished = got_done;
        end
        chk(finished, "R11 run completes", finished, 1);
        @(negedge clk); #3;
        chk(!busy, "R11 idle after done", busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        exp_base = '0; exp_wide = 1'b0; exp_burst = 1'b0;
        gnt_delay = 0; stall_len = 0; cur = '0;
        rdy_prev = 1'b0; gnt_prev = 1'b0; in_ten = 1'b0; got_done = 1'b0;
        n_addr = 0; n_data = 0; n_wr = 0; n_rel = 0; n_gap = 0;
        req_wait = 0; waited = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !bus_req && !bus_frame && !bus_addr_valid && !cfg_we && !done,
            "R1 state in reset", {busy, bus_req, bus_frame, cfg_we, done}, 0);
        #2 rst_n = 1'b1;
        @(negedge clk); #3;
        chk(!busy && !bus_req && !bus_frame && !done, "R1 idle after reset",
            {busy, bus_req, bus_frame, done}, 0);
        for (int w = 0; w < 2; w++)
            for (int b = 0; b < 2; b++)
                for (int gd = 0; gd < 3; gd += 2)
                    for (int st = 0; st < 4; st++) begin
                        if (st == 2) continue;
                        for (int k = 0; k < 2; k++)
                            run_case(w[0], b[0], gd, st,
                                     (k == 0) ? 32'h0000_1000 : 32'h8040_2A03 + 32'(16 * st),
                                     k[0]);
                    end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule